// File: doc/BRIEF.md
# Warp Memory Request Coalescer

This block sits between a warp's load issue stage and the memory hierarchy. It accepts one load request covering every lane of a warp. Each lane carries the byte address of a 4-byte word and a participation bit, and a mode bit chooses the transfer granularity: a 128-byte line when the load goes through the cache, or a 32-byte segment when it bypasses the cache. The block groups the participating lanes by the aligned region their word falls in. It then issues one downstream transaction per distinct region, carrying the region's base address and the set of lanes that region serves.

Transactions leave in ascending address order, at most one per cycle, under a valid/ready handshake. When the last one has been taken, the block pulses a completion strobe. With it come the number of transactions and a utilization ratio as two integers: the bytes actually needed, counted over distinct words, and the bytes moved. Lane order, duplicated addresses and idle lanes inside a region never add a transaction.

Top module: `warp_coalescer`

## Requirements
- R1: With `req_cached` = 1 the region is an aligned 128-byte line: every `txn_base` has its low 7 bits zero, and `done_moved` equals 128 times `done_txns`.
- R2: With `req_cached` = 0 the region is an aligned 32-byte segment: every `txn_base` has its low 5 bits zero, and `done_moved` equals 32 times `done_txns`.
- R3: Exactly one transaction is issued per distinct aligned region touched by active lanes, whatever the lane-to-address permutation or duplication. Its `txn_mask` has bit i set exactly for the active lanes i whose address lies in that region. Lane i's address occupies `req_addr[i*32 +: 32]`.
- R4: A lane with `req_active[i]` = 0 is ignored: it appears in no `txn_mask`, adds no transaction and adds nothing to `done_needed`.
- R5: Transactions are issued in strictly ascending `txn_base` order, and one is consumed on each cycle where `txn_valid` and `txn_ready` are both high. While `txn_ready` is low, `txn_base` and `txn_mask` hold steady.
- R6: `done_needed` equals 4 times the number of distinct word addresses among the active lanes.
- R7: A request with no active lanes issues no transaction. It asserts `done` in the cycle after acceptance, with `done_txns`, `done_needed` and `done_moved` all zero.
- R8: `req_ready` is high only while no request is in progress. `done` is a single-cycle pulse in the cycle after the last transaction is consumed, and `req_ready` returns the cycle after `done`.
- R9: Across one request, the transaction masks are pairwise disjoint and their union equals `req_active`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | A warp request is offered |
| req_ready | output | 1 | Block is idle and takes the request |
| req_cached | input | 1 | 1: 128-byte line granularity, 0: 32-byte segment granularity |
| req_active | input | LANES | Participation bit per lane |
| req_addr | input | LANES*AW | Byte address per lane, lane i at bits i*AW +: AW |
| txn_valid | output | 1 | A downstream transaction is offered |
| txn_ready | input | 1 | Downstream takes the transaction |
| txn_base | output | AW | Aligned base address of the region |
| txn_mask | output | LANES | Lanes served by this transaction |
| done | output | 1 | One-cycle completion strobe |
| done_txns | output | CW | Transactions issued for the request |
| done_needed | output | BW | Bytes needed (distinct words times 4) |
| done_moved | output | BW | Bytes moved (transactions times region size) |

## Verification
The hardest situation to reach is a long run of transactions whose lane order is the reverse of their address order, drained while the consumer stalls. Only there do ascending ordering, mask stability and per-lane retirement all matter together. The stimulus builds it by giving lane i an address that falls as i rises, in both modes and across widely scattered regions. Downstream ready drops on a fixed rhythm, so many transactions sit stalled for a cycle before they are taken. Misaligned runs, duplicated words, an all-same-word warp, a partly idle warp with its idle lanes pointing far away, and an empty warp cover the merge and count corners.

// File: rtl/coal_pkg.sv
package coal_pkg;

    localparam int unsigned WORD_LG = 2;   // 4-byte words
    localparam int unsigned LINE_LG = 7;   // 128-byte lines
    localparam int unsigned SEG_LG  = 5;   // 32-byte segments

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_SERVE = 2'd1,
        ST_FIN   = 2'd2
    } coal_state_e;

    function automatic int unsigned gran_lg(input logic cached);
        return cached ? LINE_LG : SEG_LG;
    endfunction

endpackage

// File: rtl/coal_min_region.sv
module coal_min_region #(
    parameter int unsigned LANES = 32,
    parameter int unsigned AW    = 32,
    localparam int unsigned SHW  = $clog2(AW)
) (
    input  logic [LANES*AW-1:0] lane_addr,
    input  logic [LANES-1:0]    pend,
    input  logic [SHW-1:0]      shift,
    output logic                found,
    output logic [AW-1:0]       min_reg,
    output logic [LANES-1:0]    hit_mask
);
    logic [AW-1:0] lane_reg [LANES];

    for (genvar g = 0; g < LANES; g++) begin : g_reg
        assign lane_reg[g] = lane_addr[g*AW +: AW] >> shift;
    end

    always_comb begin
        found   = 1'b0;
        min_reg = '0;
        for (int i = 0; i < LANES; i++) begin
            if (pend[i] && (!found || lane_reg[i] < min_reg)) begin
                min_reg = lane_reg[i];
                found   = 1'b1;
            end
        end
        for (int i = 0; i < LANES; i++) begin
            hit_mask[i] = pend[i] && (lane_reg[i] == min_reg);
        end
    end
endmodule

// File: rtl/coal_word_count.sv
module coal_word_count #(
    parameter int unsigned LANES   = 32,
    parameter int unsigned AW      = 32,
    parameter int unsigned WORD_LG = 2,
    localparam int unsigned CW     = $clog2(LANES + 1)
) (
    input  logic [LANES*AW-1:0] lane_addr,
    input  logic [LANES-1:0]    act,
    output logic [CW-1:0]       nwords
);
    logic [AW-1:0] word [LANES];

    for (genvar g = 0; g < LANES; g++) begin : g_word
        assign word[g] = lane_addr[g*AW +: AW] >> WORD_LG;
    end

    always_comb begin
        logic dup;
        nwords = '0;
        for (int i = 0; i < LANES; i++) begin
            dup = 1'b0;
            for (int j = 0; j < LANES; j++) begin
                if (j < i && act[j] && word[j] == word[i]) dup = 1'b1;
            end
            if (act[i] && !dup) nwords = nwords + CW'(1);
        end
    end
endmodule

// File: rtl/warp_coalescer.sv
module warp_coalescer
    import coal_pkg::*;
#(
    parameter int unsigned LANES = 32,
    parameter int unsigned AW    = 32,
    localparam int unsigned SHW  = $clog2(AW),
    localparam int unsigned CW   = $clog2(LANES + 1),
    localparam int unsigned BW   = $clog2(LANES * (2 ** LINE_LG) + 1)
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                req_valid,
    output logic                req_ready,
    input  logic                req_cached,
    input  logic [LANES-1:0]    req_active,
    input  logic [LANES*AW-1:0] req_addr,
    output logic                txn_valid,
    input  logic                txn_ready,
    output logic [AW-1:0]       txn_base,
    output logic [LANES-1:0]    txn_mask,
    output logic                done,
    output logic [CW-1:0]       done_txns,
    output logic [BW-1:0]       done_needed,
    output logic [BW-1:0]       done_moved
);
    coal_state_e         state_q;
    logic [LANES*AW-1:0] addr_q;
    logic [LANES-1:0]    pend_q;
    logic                cached_q;
    logic [CW-1:0]       cnt_q;
    logic [BW-1:0]       needed_q;
    logic [BW-1:0]       moved_q;

    logic [SHW-1:0]      shift;
    logic                found;
    logic [AW-1:0]       min_reg;
    logic [LANES-1:0]    hit_mask;
    logic [CW-1:0]       nwords;
    logic                take;
    logic [LANES-1:0]    pend_left;

    assign shift = SHW'(gran_lg(cached_q));

    coal_min_region #(.LANES(LANES), .AW(AW)) u_min (
        .lane_addr(addr_q),
        .pend     (pend_q),
        .shift    (shift),
        .found    (found),
        .min_reg  (min_reg),
        .hit_mask (hit_mask)
    );

    coal_word_count #(.LANES(LANES), .AW(AW), .WORD_LG(WORD_LG)) u_words (
        .lane_addr(req_addr),
        .act      (req_active),
        .nwords   (nwords)
    );

    assign req_ready   = (state_q == ST_IDLE);
    assign txn_valid   = (state_q == ST_SERVE) && found;
    assign txn_base    = min_reg << shift;
    assign txn_mask    = hit_mask;
    assign take        = txn_valid && txn_ready;
    assign pend_left   = pend_q & ~hit_mask;
    assign done        = (state_q == ST_FIN);
    assign done_txns   = cnt_q;
    assign done_needed = needed_q;
    assign done_moved  = moved_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q  <= ST_IDLE;
            addr_q   <= '0;
            pend_q   <= '0;
            cached_q <= 1'b0;
            cnt_q    <= '0;
            needed_q <= '0;
            moved_q  <= '0;
        end else begin
            unique case (state_q)
                ST_IDLE: if (req_valid) begin
                    addr_q   <= req_addr;
                    pend_q   <= req_active;
                    cached_q <= req_cached;
                    cnt_q    <= '0;
                    moved_q  <= '0;
                    needed_q <= BW'(nwords) << WORD_LG;
                    state_q  <= (|req_active) ? ST_SERVE : ST_FIN;
                end
                ST_SERVE: if (take) begin
                    pend_q  <= pend_left;
                    cnt_q   <= cnt_q + CW'(1);
                    moved_q <= moved_q + (BW'(1) << shift);
                    if (pend_left == '0) state_q <= ST_FIN;
                end
                ST_FIN:  state_q <= ST_IDLE;
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // Checker state: base of the previous transaction of this request
    logic [AW-1:0] last_base_q;
    logic          have_last_q;
    always_ff @(posedge clk) begin
        if (rst || (req_valid && req_ready)) begin
            have_last_q <= 1'b0;
            last_base_q <= '0;
        end else if (take) begin
            have_last_q <= 1'b1;
            last_base_q <= txn_base;
        end
    end

    // R5
    stall_hold_chk: assert property (@(posedge clk) disable iff (rst)
        txn_valid && !txn_ready |=> txn_valid && $stable(txn_base) && $stable(txn_mask));

    // R5
    ascending_chk: assert property (@(posedge clk) disable iff (rst)
        txn_valid && have_last_q |-> txn_base > last_base_q);

    // R9
    mask_subset_chk: assert property (@(posedge clk) disable iff (rst)
        txn_valid |-> (txn_mask != '0) && ((txn_mask & ~pend_q) == '0));

    // R1
    line_align_chk: assert property (@(posedge clk) disable iff (rst)
        txn_valid && cached_q |-> txn_base[LINE_LG-1:0] == '0);

    // R2
    seg_align_chk: assert property (@(posedge clk) disable iff (rst)
        txn_valid && !cached_q |-> txn_base[SEG_LG-1:0] == '0);

    // R8
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> !done && req_ready);

    // R1
    moved_total_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> done_moved == (BW'(done_txns) << shift));
endmodule

// File: tb/warp_coalescer_test.sv
module warp_coalescer_test;
    localparam int LANES = 32;
    localparam int AW    = 32;
    localparam int CW    = $clog2(LANES + 1);
    localparam int BW    = $clog2(LANES * 128 + 1);

    logic                clk = 1'b0;
    logic                rst = 1'b1;
    logic                req_valid = 1'b0;
    logic                req_ready;
    logic                req_cached = 1'b0;
    logic [LANES-1:0]    req_active = '0;
    logic [LANES*AW-1:0] req_addr = '0;
    logic                txn_valid;
    logic                txn_ready = 1'b0;
    logic [AW-1:0]       txn_base;
    logic [LANES-1:0]    txn_mask;
    logic                done;
    logic [CW-1:0]       done_txns;
    logic [BW-1:0]       done_needed;
    logic [BW-1:0]       done_moved;

    always #2 clk = ~clk;   // 250 MHz

    warp_coalescer #(.LANES(LANES), .AW(AW)) uut (.*);

    int checks = 0;
    int fails  = 0;
    int cycles = 0;
    int rdy_ctr = 0;
    logic [31:0] a_lane [LANES];

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            checks++; fails++;
            $display("FAIL watchdog: actual %0d expected below 150000 cycles", cycles);
            finish_run();
        end
    end

    task automatic run(input bit cached, input logic [LANES-1:0] act, input string tag);
        logic [31:0]      regs [$];
        logic [LANES-1:0] masks [$];
        bit               seen [logic [31:0]];
        int               sh;
        int               nwords;
        int               ntx;
        bit               fin;
        sh = cached ? 7 : 5;
        nwords = 0;
        for (int i = 0; i < LANES; i++) begin
            if (act[i]) begin
                logic [31:0] r;
                r = a_lane[i] >> sh;
                if (!seen.exists(a_lane[i] >> 2)) begin
                    seen[a_lane[i] >> 2] = 1'b1;
                    nwords++;
                end
                if (!(r inside {regs})) regs.push_back(r);
            end
        end
        regs.sort();
        foreach (regs[k]) begin
            logic [LANES-1:0] m;
            m = '0;
            for (int i = 0; i < LANES; i++)
                m[i] = act[i] && ((a_lane[i] >> sh) == regs[k]);
            masks.push_back(m);
        end
        ntx = regs.size();

        @(negedge clk);
        check(req_ready == 1'b1, "R8", {tag, " ready when idle"}, req_ready, 1);
        req_valid  = 1'b1;
        req_cached = cached;
        req_active = act;
        for (int i = 0; i < LANES; i++) req_addr[i*AW +: AW] = a_lane[i];
        @(negedge clk);
        req_valid = 1'b0;
        fin = 1'b0;
        for (int cyc = 0; cyc < 400 && !fin; cyc++) begin
            rdy_ctr++;
            txn_ready = (rdy_ctr % 3) != 0;
            if (done) begin
                fin = 1'b1;
                check(regs.size() == 0, "R3", {tag, " leftover regions"}, regs.size(), 0);
                check(done_txns == CW'(ntx), "R3", {tag, " txn count"}, done_txns, ntx);
                check(done_needed == BW'(nwords * 4), "R6", {tag, " bytes needed"},
                      done_needed, nwords * 4);
                check(done_moved == BW'(ntx << sh), cached ? "R1" : "R2",
                      {tag, " bytes moved"}, done_moved, ntx << sh);
                check(txn_valid == 1'b0, "R8", {tag, " no txn at done"}, txn_valid, 0);
            end else begin
                check(req_ready == 1'b0, "R8", {tag, " busy not ready"}, req_ready, 0);
                if (txn_valid && txn_ready) begin
                    if (regs.size() == 0) begin
                        check(1'b0, "R3", {tag, " extra txn"}, txn_base, 0);
                    end else begin
                        logic [31:0]      eb;
                        logic [LANES-1:0] em;
                        eb = regs.pop_front() << sh;
                        em = masks.pop_front();
                        check(txn_base == eb, "R5", {tag, " base order"}, txn_base, eb);
                        check(txn_mask == em, "R9", {tag, " lane mask"}, txn_mask, em);
                    end
                end
            end
            @(negedge clk);
        end
        check(fin, "R8", {tag, " done seen"}, fin, 1);
        check(done == 1'b0 && req_ready == 1'b1, "R8", {tag, " done single pulse"},
              {done, req_ready}, 2'b01);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(txn_valid == 0, "R8", "reset txn_valid", txn_valid, 0);
        check(done == 0, "R8", "reset done", done, 0);
        check(req_ready == 1, "R8", "reset ready", req_ready, 1);

        // R1 aligned consecutive, one line
        for (int i = 0; i < LANES; i++) a_lane[i] = 32'h1000 + 4 * i;
        run(1'b1, '1, "R1 aligned line");
        // R3 permuted words in one line
        for (int i = 0; i < LANES; i++) a_lane[i] = 32'h2000 + 4 * ((i * 7) % 32);
        run(1'b1, '1, "R3 permuted line");
        // R1 misaligned spans two lines
        for (int i = 0; i < LANES; i++) a_lane[i] = 32'h3010 + 4 * i;
        run(1'b1, '1, "R1 misaligned line");
        // R6 all lanes same word, both modes
        for (int i = 0; i < LANES; i++) a_lane[i] = 32'h5044;
        run(1'b1, '1, "R6 same word cached");
        run(1'b0, '1, "R6 same word uncached");
        // R2 aligned consecutive, four segments
        for (int i = 0; i < LANES; i++) a_lane[i] = 32'h1000 + 4 * i;
        run(1'b0, '1, "R2 aligned segments");
        // R2 misaligned, five segments
        for (int i = 0; i < LANES; i++) a_lane[i] = 32'h3010 + 4 * i;
        run(1'b0, '1, "R2 misaligned segments");
        // R5 scattered, lane order opposite address order
        for (int i = 0; i < LANES; i++) a_lane[i] = 32'h8000 + 32'h200 * (LANES - 1 - i);
        run(1'b1, '1, "R5 scatter cached");
        for (int i = 0; i < LANES; i++) a_lane[i] = 32'h9000 + 64 * (LANES - 1 - i) + 4;
        run(1'b0, '1, "R5 scatter uncached");
        // R6 pairs share a word
        for (int i = 0; i < LANES; i++) a_lane[i] = 32'h4000 + 4 * (i & ~1);
        run(1'b0, '1, "R6 paired words");
        // R4 every fourth lane idle, idle lanes point far away
        for (int i = 0; i < LANES; i++)
            a_lane[i] = (i % 4 == 0) ? 32'hFFFF_0000 + 32'h100 * i : 32'h6000 + 4 * i;
        begin
            logic [LANES-1:0] m;
            for (int i = 0; i < LANES; i++) m[i] = (i % 4) != 0;
            run(1'b1, m, "R4 partial warp");
            run(1'b0, m, "R4 partial warp uncached");
        end
        // R7 no active lanes
        run(1'b1, '0, "R7 empty warp");
        // R9 two interleaved regions, sparse mask
        for (int i = 0; i < LANES; i++) a_lane[i] = (i % 2) ? 32'hA000 + 4 * i : 32'h7000 + 4 * i;
        run(1'b1, 32'h0F0F_00FF, "R9 interleaved");

        finish_run();
    end
endmodule